// File: doc/BRIEF.md
# PCM Sample Buffer with Replay and Loop

A processor fills this byte-wide sample buffer one write at a time. A rate-driven reader drains it and assembles left and right 16-bit PCM samples. Each frame is 1, 2 or 4 bytes: 8-bit or 16-bit data, in mono or stereo. The control register has three jobs:

- a full flush, which clears both the read and the write pointer;
- a rewind, which moves only the read pointer back to address 0, so a stored sample can be played again without refilling;
- a mode select for sample width and channel count.

The rate register sets the playback speed and can also enable looping. In loop mode the reader rewinds on its own whenever it finds the buffer drained. A rewind, commanded or automatic, is applied only while the frame reader is idle, so a frame is never split.

The pointers are raw buffer addresses. Replay and loop give the intended result only when a flush came before the sample was written.

Top module: `pcm_replay_fifo`

## Requirements
- R1: After reset both sample outputs are 0, `valid_o` is low, `empty_o` is high and `full_o` is low.
- R2: A pulse on `data_we_i` stores one byte. `full_o` rises once 2^ADDR_W bytes are unread. A write while `full_o` is high is dropped and does not change the stored data.
- R3: A control write with bit 7 set clears both pointers, returns the frame reader to idle and drops any pending rewind. If bit 6 is set in the same write, bit 7 still wins, and `empty_o` is high afterwards.
- R4: A control write with bit 6 set (and bit 7 clear) sets the read pointer to 0. The write pointer and the stored bytes are left as they were, so the same frames play again.
- R5: A rewind requested while a frame is being gathered is held until that frame has been delivered in full. It is then applied in the next idle cycle.
- R6: When rate bit 7 is set and the rate value is not 0x80, a reader that is idle and finds the buffer empty rewinds to address 0 and playback continues from there.
- R7: Bits 6:0 of the rate value are added every clock to a 7-bit accumulator, and each carry out of it starts one frame. A rate of 0 stops playback. A rate of 0x80 starts a frame on every idle cycle, with looping off.
- R8: Control bit 5 selects 16-bit data and control bit 4 selects stereo. Both are latched on every control write. Bytes are taken in this order: left low, left high, right low, right high. An 8-bit sample is placed in the upper byte of its output. In mono the same sample drives both outputs.
- R9: When the buffer is empty and looping is off, no frame starts and both sample outputs hold their last values.
- R10: `valid_o` pulses for one cycle each time a newly assembled frame appears on the sample outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_we_i | input | 1 | Write one sample byte |
| data_i | input | 8 | Sample byte |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_i | input | 8 | Control value: bit 7 flush, bit 6 rewind, bit 5 16-bit, bit 4 stereo |
| rate_we_i | input | 1 | Rate register write strobe |
| rate_i | input | 8 | Rate value: bit 7 loop, bits 6:0 rate |
| left_o | output | 16 | Left sample |
| right_o | output | 16 | Right sample |
| valid_o | output | 1 | New frame presented |
| full_o | output | 1 | Buffer full |
| empty_o | output | 1 | Buffer empty |

## Verification
The assertions check a set of pointer and state rules on every cycle:

- a write to a full buffer leaves the write pointer unchanged;
- a flush always empties the buffer;
- a rewind clears only the read pointer;
- a rewind never coincides with a byte fetch;
- the full and empty flags are never both high;
- the delivery state is entered only from a fetch state.

Other behaviour shows only through the bench's scenarios, compared against its cycle-level model. These cover the frame byte order in each format, replay of the same frames after a rewind, a rewind deferred past the right byte of an 8-bit stereo frame, continuous loop wraparound, held output on underrun, and a rate of zero stopping playback.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;
  typedef enum logic [2:0] {
    RD_IDLE = 3'd0,
    RD_B0   = 3'd1,
    RD_B1   = 3'd2,
    RD_B2   = 3'd3,
    RD_B3   = 3'd4,
    RD_DONE = 3'd5
  } rd_state_e;

  localparam logic [7:0] RateMax = 8'h80;
endpackage

// File: rtl/pcm_byte_store.sv
module pcm_byte_store #(
  parameter int ADDR_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic       rewind_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       pop_i,
  output logic [7:0] rd_data_o,
  output logic       full_o,
  output logic       empty_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q, fill;
  logic          wr_ok;

  assign fill    = wr_q - rd_q;
  assign full_o  = (fill == PW'(DEPTH));
  assign empty_o = (fill == '0);
  assign wr_ok   = wr_en_i && !full_o && !flush_i;
  assign rd_data_o = mem_q[rd_q[ADDR_W-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_q[ADDR_W-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (flush_i) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (wr_ok) wr_q <= wr_q + 1'b1;
      if (rewind_i)                rd_q <= '0;
      else if (pop_i && !empty_o)  rd_q <= rd_q + 1'b1;
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_en_i && !flush_i |=> $stable(wr_q));
  p_rewind_keeps_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_i && !flush_i && !wr_en_i |=> (rd_q == '0) && $stable(wr_q));
  p_flush_empties_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  p_flags_exclusive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({full_o, empty_o}));
endmodule

// File: rtl/pcm_rate_gen.sv
module pcm_rate_gen
  import pcm_fifo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rate_we_i,
  input  logic [7:0] rate_i,
  output logic       tick_o,
  output logic       loop_o
);
  logic [7:0] rate_q;
  logic [6:0] acc_q;
  logic [7:0] sum;
  logic       max_rate;

  assign max_rate = (rate_q == RateMax);
  assign sum      = {1'b0, acc_q} + {1'b0, rate_q[6:0]};
  assign tick_o   = max_rate || sum[7];
  assign loop_o   = rate_q[7] && !max_rate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      acc_q  <= '0;
    end else begin
      acc_q <= sum[6:0];
      if (rate_we_i) rate_q <= rate_i;
    end
  end
endmodule

// File: rtl/pcm_frame_reader.sv
module pcm_frame_reader
  import pcm_fifo_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic        rewind_req_i,
  input  logic        tick_i,
  input  logic        loop_i,
  input  logic        is16_i,
  input  logic        stereo_i,
  input  logic        empty_i,
  input  logic [7:0]  byte_i,
  output logic        pop_o,
  output logic        rewind_o,
  output logic [15:0] left_o,
  output logic [15:0] right_o,
  output logic        valid_o
);
  rd_state_e       state_q, state_d;
  logic            pend_q;
  logic [3:0][7:0] byte_q;
  logic [2:0]      st_m1;
  logic [1:0]      idx, last_idx;
  logic            fetching;
  logic [15:0]     left_q, right_q;
  logic            valid_q;

  assign st_m1    = state_q - 3'd1;
  assign idx      = st_m1[1:0];
  assign last_idx = {is16_i && stereo_i, is16_i || stereo_i};
  assign fetching = (state_q inside {RD_B0, RD_B1, RD_B2, RD_B3});
  assign pop_o    = fetching && !empty_i && !flush_i;
  assign rewind_o = (state_q == RD_IDLE) && (pend_q || (loop_i && empty_i)) && !flush_i;

  always_comb begin
    state_d = state_q;
    if (flush_i) state_d = RD_IDLE;
    else begin
      unique case (state_q)
        RD_IDLE: if (!rewind_o && tick_i && !empty_i) state_d = RD_B0;
        RD_DONE: state_d = RD_IDLE;
        default: state_d = (idx == last_idx) ? RD_DONE : rd_state_e'(state_q + 3'd1);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      pend_q  <= 1'b0;
      byte_q  <= '0;
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (flush_i)           pend_q <= 1'b0;
      else if (rewind_req_i) pend_q <= 1'b1;
      else if (rewind_o)     pend_q <= 1'b0;
      if (fetching && !flush_i) byte_q[idx] <= empty_i ? 8'h00 : byte_i;
      valid_q <= (state_q == RD_DONE) && !flush_i;
      if (state_q == RD_DONE && !flush_i) begin
        unique case ({is16_i, stereo_i})
          2'b00: begin left_q <= {byte_q[0], 8'h00}; right_q <= {byte_q[0], 8'h00}; end
          2'b01: begin left_q <= {byte_q[0], 8'h00}; right_q <= {byte_q[1], 8'h00}; end
          2'b10: begin left_q <= {byte_q[1], byte_q[0]}; right_q <= {byte_q[1], byte_q[0]}; end
          default: begin left_q <= {byte_q[1], byte_q[0]}; right_q <= {byte_q[3], byte_q[2]}; end
        endcase
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

  p_done_from_fetch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == RD_DONE |-> $past(state_q) inside {RD_B0, RD_B1, RD_B2, RD_B3});
endmodule

// File: rtl/pcm_replay_fifo.sv
module pcm_replay_fifo
  import pcm_fifo_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        data_we_i,
  input  logic [7:0]  data_i,
  input  logic        ctrl_we_i,
  input  logic [7:0]  ctrl_i,
  input  logic        rate_we_i,
  input  logic [7:0]  rate_i,
  output logic [15:0] left_o,
  output logic [15:0] right_o,
  output logic        valid_o,
  output logic        full_o,
  output logic        empty_o
);
  logic       flush, rewind_req, rewind, pop, tick, loop_en;
  logic       is16_q, stereo_q;
  logic [7:0] rd_byte;

  assign flush      = ctrl_we_i && ctrl_i[7];
  assign rewind_req = ctrl_we_i && ctrl_i[6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is16_q   <= 1'b0;
      stereo_q <= 1'b0;
    end else if (ctrl_we_i) begin
      is16_q   <= ctrl_i[5];
      stereo_q <= ctrl_i[4];
    end
  end

  pcm_byte_store #(.ADDR_W(ADDR_W)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush),
    .rewind_i  (rewind),
    .wr_en_i   (data_we_i),
    .wr_data_i (data_i),
    .pop_i     (pop),
    .rd_data_o (rd_byte),
    .full_o    (full_o),
    .empty_o   (empty_o)
  );

  pcm_rate_gen i_rate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rate_we_i (rate_we_i),
    .rate_i    (rate_i),
    .tick_o    (tick),
    .loop_o    (loop_en)
  );

  pcm_frame_reader i_reader (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush),
    .rewind_req_i (rewind_req),
    .tick_i       (tick),
    .loop_i       (loop_en),
    .is16_i       (is16_q),
    .stereo_i     (stereo_q),
    .empty_i      (empty_o),
    .byte_i       (rd_byte),
    .pop_o        (pop),
    .rewind_o     (rewind),
    .left_o       (left_o),
    .right_o      (right_o),
    .valid_o      (valid_o)
  );

  // rewind and fetch come from different branches of the reader
  p_rewind_idle_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind |-> !pop);
endmodule

// File: tb/test_pcm_replay_fifo.sv
module test_pcm_replay_fifo;
  localparam int AW = 4;
  localparam int D  = 1 << AW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic data_we = 0, ctrl_we = 0, rate_we = 0;
  logic [7:0] data_d = 0, ctrl_d = 0, rate_d = 0;
  logic [15:0] left_o, right_o;
  logic valid_o, full_o, empty_o;

  always #4 clk = ~clk;

  pcm_replay_fifo #(.ADDR_W(AW)) i_pcm_replay_fifo (
    .clk_i(clk), .rst_ni(rst_ni),
    .data_we_i(data_we), .data_i(data_d),
    .ctrl_we_i(ctrl_we), .ctrl_i(ctrl_d),
    .rate_we_i(rate_we), .rate_i(rate_d),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .full_o(full_o), .empty_o(empty_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] fq[$];

  // behavioural reference: state 0 idle, 1..4 byte fetch, 5 deliver
  int m_wr, m_rd, m_st, m_acc;
  logic [7:0] m_rate, m_mem [D], m_b [4];
  bit m_pend, m_16, m_st2, m_v;
  logic [15:0] m_l, m_r;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_wr = 0; m_rd = 0; m_st = 0; m_acc = 0; m_rate = 0;
      m_pend = 0; m_16 = 0; m_st2 = 0; m_v = 0; m_l = 0; m_r = 0;
      for (int i = 0; i < 4; i++) m_b[i] = 0;
    end else begin
      int fill, nb, nst;
      bit tick, lp, emp, ful, fl, rw, nv;
      fill = (m_wr - m_rd) & (2*D - 1);
      emp = (fill == 0); ful = (fill == D);
      tick = (m_rate == 8'h80) || (m_acc + (m_rate & 127) >= 128);
      lp = m_rate[7] && (m_rate != 8'h80);
      fl = ctrl_we && ctrl_d[7];
      rw = (m_st == 0) && (m_pend || (lp && emp)) && !fl;
      nb = (m_16 ? 2 : 1) * (m_st2 ? 2 : 1);
      nst = m_st; nv = 0;
      if (m_st == 0) begin
        if (!rw && tick && !emp) nst = 1;
      end else if (m_st == 5) begin
        nst = 0;
        if (!fl) begin
          nv = 1;
          case ({m_16, m_st2})
            2'b00: begin m_l = {m_b[0], 8'h00}; m_r = m_l; end
            2'b01: begin m_l = {m_b[0], 8'h00}; m_r = {m_b[1], 8'h00}; end
            2'b10: begin m_l = {m_b[1], m_b[0]}; m_r = m_l; end
            default: begin m_l = {m_b[1], m_b[0]}; m_r = {m_b[3], m_b[2]}; end
          endcase
        end
      end else if (!fl) begin
        m_b[m_st-1] = emp ? 8'h00 : m_mem[m_rd % D];
        nst = (m_st == nb) ? 5 : m_st + 1;
      end
      if (fl) begin m_wr = 0; m_rd = 0; nst = 0; end
      else begin
        if (rw) m_rd = 0;
        else if (m_st >= 1 && m_st <= 4 && !emp) m_rd = (m_rd + 1) % (2*D);
        if (data_we && !ful) begin m_mem[m_wr % D] = data_d; m_wr = (m_wr + 1) % (2*D); end
      end
      if (fl) m_pend = 0; else if (ctrl_we && ctrl_d[6]) m_pend = 1; else if (rw) m_pend = 0;
      if (ctrl_we) begin m_16 = ctrl_d[5]; m_st2 = ctrl_d[4]; end
      m_acc = (m_acc + (m_rate & 127)) & 127;
      if (rate_we) m_rate = rate_d;
      m_st = nst; m_v = nv;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    int fill;
    cyc++;
    fill = (m_wr - m_rd) & (2*D - 1);
    chk(left_o == m_l, "R8 left", left_o, m_l);
    chk(right_o == m_r, "R8 right", right_o, m_r);
    chk(valid_o == m_v, "R10 valid", valid_o, m_v);
    chk(full_o == (fill == D), "R2 full", full_o, fill == D);
    chk(empty_o == (fill == 0), "R2 empty", empty_o, fill == 0);
    if (valid_o) fq.push_back({left_o, right_o});
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // tasks are entered at a negedge and return at a negedge
  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1; ctrl_d = v; @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_rate(input logic [7:0] v);
    rate_we = 1; rate_d = v; @(negedge clk); rate_we = 0;
  endtask
  task automatic wr_data(input logic [7:0] v);
    data_we = 1; data_d = v; @(negedge clk); data_we = 0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(left_o == 0 && right_o == 0, "R1 samples", {left_o, right_o}, 0);
    chk(!valid_o && empty_o && !full_o, "R1 flags", {valid_o, empty_o, full_o}, 3'b010);

    // R8 8-bit stereo, R4 rewind replay, R5 deferral mid-frame
    wr_ctrl(8'h90);
    wr_data(8'h11); wr_data(8'h22); wr_data(8'h33); wr_data(8'h44);
    fq.delete();
    wr_rate(8'h80);
    while (fq.size() < 1) @(negedge clk);
    while (m_st != 2) @(negedge clk);
    wr_ctrl(8'h50);
    idle(40);
    chk(fq.size() == 4, "R5 frame count", fq.size(), 4);
    chk(fq[1] == {16'h3300, 16'h4400}, "R5 frame not split", fq[1], {16'h3300, 16'h4400});
    chk(fq[2] == {16'h1100, 16'h2200}, "R4 replay first frame", fq[2], {16'h1100, 16'h2200});
    chk(fq[3] == {16'h3300, 16'h4400}, "R4 replay second frame", fq[3], {16'h3300, 16'h4400});
    // R9 hold on underrun
    chk(left_o == 16'h3300 && right_o == 16'h4400, "R9 held", {left_o, right_o}, {16'h3300, 16'h4400});

    // R6 loop, 16-bit mono
    wr_rate(8'h00);
    wr_ctrl(8'hA0);
    wr_data(8'h01); wr_data(8'h02); wr_data(8'h03); wr_data(8'h04);
    fq.delete();
    wr_rate(8'hC0);
    while (fq.size() < 6) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      logic [15:0] e;
      e = (i % 2 == 0) ? 16'h0201 : 16'h0403;
      chk(fq[i] == {e, e}, "R6 loop wrap", fq[i], {e, e});
    end

    // R7 rate 0 stops
    wr_rate(8'h00);
    idle(10);
    fq.delete();
    idle(60);
    chk(fq.size() == 0, "R7 rate zero", fq.size(), 0);

    // R2 full and dropped writes, 8-bit mono
    wr_ctrl(8'h80);
    for (int i = 1; i <= D + 4; i++) wr_data(8'(i));
    chk(full_o == 1'b1, "R2 full flag", full_o, 1);
    fq.delete();
    wr_rate(8'h80);
    idle(4 * D + 20);
    chk(fq.size() == D, "R2 frames after full", fq.size(), D);
    chk(left_o == {8'(D), 8'h00} && right_o == left_o, "R2 extra writes dropped", {left_o, right_o}, {8'(D), 8'h00, 8'(D), 8'h00});

    // R7 slow rate still plays through, phase accumulator
    wr_rate(8'h00);
    wr_ctrl(8'h80);
    wr_data(8'h5A); wr_data(8'h6B);
    fq.delete();
    wr_rate(8'h05);
    idle(120);
    chk(fq.size() == 2, "R7 slow rate frames", fq.size(), 2);

    // R3 flush dominates rewind
    wr_rate(8'h00);
    wr_data(8'h77); wr_data(8'h78);
    wr_ctrl(8'hC0);
    idle(3);
    chk(empty_o == 1'b1, "R3 flush empties", empty_o, 1);

    // R8 16-bit stereo byte order
    wr_ctrl(8'hB0);
    for (int i = 1; i <= 8; i++) wr_data(8'hA0 + 8'(i));
    fq.delete();
    wr_rate(8'h80);
    idle(30);
    chk(fq.size() == 2, "R8 stereo16 count", fq.size(), 2);
    chk(fq[0] == 32'hA2A1_A4A3, "R8 stereo16 first", fq[0], 32'hA2A1_A4A3);
    chk(fq[1] == 32'hA6A5_A8A7, "R8 stereo16 second", fq[1], 32'hA6A5_A8A7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule